// File: doc/BRIEF.md
# Calendar Time Stamp Capture

This block freezes a copy of the running calendar when an external event pin toggles in a chosen direction. One of two pins is picked as the event source. The chosen pin passes through a two-flop synchronizer and then an edge detector. A qualifying edge copies the live time and date words into holding registers and raises a stamp flag. If the stamp flag is still set when a further event arrives, the holding registers keep the first capture and an overflow flag is raised instead.

Software clears each flag with a one-cycle strobe. An interrupt line follows the stamp flag whenever the interrupt enable is set. The calendar counters and the register bus that drive this block are outside it.

Top module: `ts_capture`

## Requirements
- R1: After reset, `tsf`, `tsof`, `irq`, `ts_time` and `ts_date` are all zero.
- R2: With `ts_en`=1, a qualifying edge on the selected pin loads `cal_time`/`cal_date` into `ts_time`/`ts_date` and sets `tsf`.
- R3: An event that arrives while `tsf` is 1, with no clear in the same cycle, sets `tsof` and leaves `ts_time`/`ts_date` unchanged.
- R4: `irq` is 1 exactly when `tsf` is 1 and `ts_ie` is 1.
- R5: `pin_sel`=0 selects `pin_a` and `pin_sel`=1 selects `pin_b`. Edges on the unselected pin have no effect.
- R6: `edge_fall`=0 makes a 0-to-1 transition qualify, and `edge_fall`=1 makes a 1-to-0 transition qualify. A transition in the other direction is ignored.
- R7: A `clr_tsf` strobe with no event in the same cycle clears `tsf`, and therefore `irq`. A `clr_tsof` strobe clears `tsof`. Neither strobe affects the other flag.
- R8: An event in the same cycle as `clr_tsf` counts as a new event. It captures the calendar, `tsf` stays 1, and `tsof` is not set.
- R9: With `ts_en`=0, pin edges change neither the flags nor the captured registers.
- R10: A pin change applied between clock edges shows on `tsf` after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Event pin 0 |
| pin_b | input | 1 | Event pin 1 |
| pin_sel | input | 1 | Event pin select (0 = pin_a, 1 = pin_b) |
| edge_fall | input | 1 | Active edge (0 = rising, 1 = falling) |
| ts_en | input | 1 | Capture enable |
| ts_ie | input | 1 | Interrupt enable |
| cal_time | input | TIME_W | Live calendar time |
| cal_date | input | DATE_W | Live calendar date |
| clr_tsf | input | 1 | Stamp flag clear strobe |
| clr_tsof | input | 1 | Overflow flag clear strobe |
| ts_time | output | TIME_W | Captured time |
| ts_date | output | DATE_W | Captured date |
| tsf | output | 1 | Stamp flag |
| tsof | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted synchronizer or edge register shows up as a wrong arrival cycle for the stamp flag, or as a stamp taken on the wrong edge. This is visible within three clock cycles of the pin change. A stale or wrongly gated flag appears on the next event as a missing overflow, as an overwritten capture, or as an overflow after a same-cycle clear. The bench checks every port on every cycle of a random run against a cycle model, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int TIME_W = 23,
  parameter int DATE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              pin_sel,
  input  logic              edge_fall,
  input  logic              ts_en,
  input  logic              ts_ie,
  input  logic [TIME_W-1:0] cal_time,
  input  logic [DATE_W-1:0] cal_date,
  input  logic              clr_tsf,
  input  logic              clr_tsof,
  output logic [TIME_W-1:0] ts_time,
  output logic [DATE_W-1:0] ts_date,
  output logic              tsf,
  output logic              tsof,
  output logic              irq
);

  logic [2:0] pin_sh;
  logic       pin_raw;
  logic       evt;
  logic       take;

  assign pin_raw = pin_sel ? pin_b : pin_a;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[1:0], pin_raw};

  assign evt  = ts_en & (edge_fall ? (~pin_sh[1] & pin_sh[2])
                                   : (pin_sh[1] & ~pin_sh[2]));
  assign take = evt & (~tsf | clr_tsf);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ts_time <= '0;
      ts_date <= '0;
    end else if (take) begin
      ts_time <= cal_time;
      ts_date <= cal_date;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tsf <= 1'b0;
    else if (evt)     tsf <= 1'b1;
    else if (clr_tsf) tsf <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      tsof <= 1'b0;
    else if (evt && tsf && !clr_tsf) tsof <= 1'b1;
    else if (clr_tsof)               tsof <= 1'b0;

  assign irq = tsf & ts_ie;

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> tsf); // R2
  AST_OVF_KEEPS_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && tsf && !clr_tsf) |=> ($stable(ts_time) && $stable(ts_date) && tsof)); // R3
  AST_CLR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tsf && !evt) |=> !tsf); // R7
  AST_SAME_CYCLE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr_tsf && !tsof) |=> (tsf && !tsof)); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ts_en && !tsf) |=> !tsf); // R9
  AST_STAMP_ONLY_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> ($stable(ts_time) && $stable(ts_date))); // R2

endmodule

// File: tb/sim_ts_capture.sv
module sim_ts_capture;
  localparam int TW = 23;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 0, pin_b = 0, pin_sel = 0, edge_fall = 0, ts_en = 0, ts_ie = 0;
  logic clr_tsf = 0, clr_tsof = 0;
  logic [TW-1:0] cal_time = '0;
  logic [DW-1:0] cal_date = '0;
  logic [TW-1:0] ts_time;
  logic [DW-1:0] ts_date;
  logic tsf, tsof, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0] m_sh;
  logic m_tsf, m_tsof;
  logic [TW-1:0] m_time;
  logic [DW-1:0] m_date;

  always #4 clk = ~clk;

  ts_capture #(.TIME_W(TW), .DATE_W(DW)) u0 (
    .clk, .rst_n, .pin_a, .pin_b, .pin_sel, .edge_fall, .ts_en, .ts_ie,
    .cal_time, .cal_date, .clr_tsf, .clr_tsof,
    .ts_time, .ts_date, .tsf, .tsof, .irq);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_evt();
    return ts_en & (edge_fall ? (~m_sh[1] & m_sh[2]) : (m_sh[1] & ~m_sh[2]));
  endfunction

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic model_step();
    logic e;
    e = m_evt();
    if (e && (!m_tsf || clr_tsf)) begin m_time = cal_time; m_date = cal_date; end
    if (e && m_tsf && !clr_tsf) m_tsof = 1;
    else if (clr_tsof) m_tsof = 0;
    if (e) m_tsf = 1;
    else if (clr_tsf) m_tsf = 0;
    m_sh = {m_sh[1:0], pin_sel ? pin_b : pin_a};
  endtask

  task automatic pulse_clr(bit f, bit o);
    clr_tsf = f; clr_tsof = o;
    cyc(1);
    clr_tsf = 0; clr_tsof = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5));
    cyc(2);
    chk("R1 tsf", tsf, 0); chk("R1 tsof", tsof, 0); chk("R1 irq", irq, 0);
    chk("R1 time", ts_time, 0); chk("R1 date", ts_date, 0);
    rst_n = 1;
    cyc(2);
    ts_en = 1; cal_time = 23'h12345; cal_date = 24'hABCDE;
    pin_a = 1;
    cyc(2); chk("R10 not yet", tsf, 0);
    cyc(1); chk("R10/R2 tsf", tsf, 1);
    chk("R2 time", ts_time, 23'h12345); chk("R2 date", ts_date, 24'hABCDE);
    chk("R4 irq off", irq, 0);
    ts_ie = 1; #1; chk("R4 irq on", irq, 1);
    cal_time = 23'h00777; cal_date = 24'h0F0F0;
    pin_a = 0; cyc(4); chk("R6 fall ignored", tsof, 0);
    pin_a = 1; cyc(4);
    chk("R3 tsof", tsof, 1); chk("R3 time kept", ts_time, 23'h12345);
    chk("R3 date kept", ts_date, 24'hABCDE);
    pulse_clr(1, 0);
    chk("R7 tsf clr", tsf, 0); chk("R7 irq clr", irq, 0); chk("R7 tsof kept", tsof, 1);
    pulse_clr(0, 1);
    chk("R7 tsof clr", tsof, 0);
    pin_sel = 1; cyc(4);
    pin_a = 0; cyc(4); pin_a = 1; cyc(4);
    chk("R5 unselected", tsf, 0);
    pin_b = 1; cyc(4);
    chk("R5 pin_b tsf", tsf, 1); chk("R5 pin_b time", ts_time, 23'h00777);
    pin_b = 0; cyc(4);
    cal_time = 23'h55AA5; cal_date = 24'h13579;
    pin_b = 1; cyc(2);
    clr_tsf = 1; cyc(1); clr_tsf = 0;
    chk("R8 tsf", tsf, 1); chk("R8 tsof", tsof, 0); chk("R8 time", ts_time, 23'h55AA5);
    pulse_clr(1, 1);
    edge_fall = 1; cal_time = 23'h0BEEF;
    pin_b = 0; cyc(4);
    chk("R6 falling tsf", tsf, 1); chk("R6 falling time", ts_time, 23'h0BEEF);
    pulse_clr(1, 0);
    pin_b = 1; cyc(4);
    chk("R6 rising ignored", tsf, 0);
    ts_en = 0; cal_time = 23'h00001;
    pin_b = 0; cyc(4); pin_b = 1; cyc(4);
    chk("R9 tsf", tsf, 0); chk("R9 time", ts_time, 23'h0BEEF);

    rst_n = 0; cyc(2);
    m_sh = '0; m_tsf = 0; m_tsof = 0; m_time = '0; m_date = '0;
    rst_n = 1;
    for (int i = 0; i < 4000; i++) begin
      pin_a = ($urandom % 4 == 0) ? ~pin_a : pin_a;
      pin_b = ($urandom % 4 == 0) ? ~pin_b : pin_b;
      pin_sel = ($urandom % 50 == 0) ? ~pin_sel : pin_sel;
      edge_fall = ($urandom % 80 == 0) ? ~edge_fall : edge_fall;
      ts_en = ($urandom % 10 != 0);
      ts_ie = $urandom % 2;
      clr_tsf = ($urandom % 12 == 0);
      clr_tsof = ($urandom % 20 == 0);
      cal_time = TW'($urandom);
      cal_date = DW'($urandom);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("R2 rnd tsf", tsf, m_tsf);
      chk("R3 rnd tsof", tsof, m_tsof);
      chk("R3 rnd time", ts_time, m_time);
      chk("R3 rnd date", ts_date, m_date);
      chk("R4 rnd irq", irq, m_tsf & ts_ie);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule